// File: doc/BRIEF.md
# Calibration Sample Capture Controller

This block runs sample acquisition for a laser power calibration unit. Four 8-bit unsigned channels arrive together as one bundle: the write-power level, two reflection levels and a calibration level. A frame-sync strobe paces everything. The block stores selected channels into an internal RAM. During a test write it stores the write-power sample for each location. During the later read-back pass it stores the three read-back levels for that same location in the words right beside it.

While test writing, it also steps an 8-bit power setting once per frame, starting from a programmed base value. A host starts a run with `start_i` and sets the number of locations. It waits for `done_o`, then reads the RAM through a plain synchronous read port. A detector-only mode keeps the block consuming samples and tracking sync without touching the RAM or the power setting.

The sample bundle uses a valid/ready handshake. Bundles are consumed at once (`smp_ready_o` high) whenever the block is not storing words. After a bundle is captured, ready stays low while its words go into the RAM one per cycle: 1 cycle for a write-power capture and 3 cycles for a read-back capture. Bundles that arrive when no capture is armed are accepted and dropped. Control pins and status pins carry no handshake.

Top module: `cal_capture_ctrl`

## Requirements
- R1: `mode_i` codes are: 0 = stepped test write, 1 = constant-power write, 2 = read-back, 3 = normal read, 4 = DVD read, 5 = detector-only. Codes 6 and 7 act like normal read. Only codes 0 and 2 ever write the RAM.
- R2: In mode 0, the write-power sample of location k is stored at word address {k, 2'b00}. Here k is the 4-bit location index, in the high address bits.
- R3: In mode 2, the two reflection levels and the calibration level of location k are stored at {k, 2'b01}, {k, 2'b10} and {k, 2'b11}. Each `start_i` restarts k at 0, so read-back values land beside the write-power sample of the same location.
- R4: In mode 5, no RAM word changes and the location count does not advance. `pwr_o` holds its value and `done_o` stays low.
- R5: `start_i` loads `pwr_o` from `pwr_base_i`. In mode 0, the first sync rising edge after start leaves `pwr_o` unchanged. Each later sync rising edge adds 1, saturating at 255.
- R6: In mode 1, `pwr_o` stays at the loaded base value across sync edges.
- R7: The mode is sampled only on a sync rising edge. That edge arms one capture, which takes the next accepted bundle. A later change of `mode_i` does not alter an armed capture. A bundle with no armed capture before it is dropped.
- R8: After a capture, `smp_ready_o` is low for exactly 1 cycle in mode 0 and for exactly 3 cycles in mode 2. Otherwise it is high.
- R9: `done_o` rises once the programmed number of locations has been captured. It then holds, with no further capture or power step, until `start_i`. A `num_loc_i` of 0 or above 16 means 16.
- R10: After reset, `pwr_o` is 0, `done_o` is 0, `smp_ready_o` is 1 and every RAM word reads 0.
- R11: `rd_data_o` shows the RAM word at `rd_addr_i` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| mode_i | input | 3 | Operating mode code |
| num_loc_i | input | 5 | Locations per run (0 or over 16 means 16) |
| pwr_base_i | input | 8 | Power setting loaded at start |
| sync_i | input | 1 | Frame sync; action on its rising edge |
| smp_valid_i | input | 1 | Sample bundle valid |
| smp_ready_o | output | 1 | Sample bundle ready |
| smp_pw_i | input | 8 | Write-power sample |
| smp_a1_i | input | 8 | First reflection sample |
| smp_a2_i | input | 8 | Second reflection sample |
| smp_calf_i | input | 8 | Calibration sample |
| rd_addr_i | input | 6 | RAM read word address |
| rd_data_o | output | 8 | RAM read data, one cycle latency |
| pwr_o | output | 8 | Current power setting |
| done_o | output | 1 | Run complete |

## Verification
The write path is tried with stepped test writes from a mid-range base, with a base just under the ceiling, and with full 16-location runs using the 0 and oversize count codes. Comparing these separates increment, saturation and count clamping faults. Read-back runs over the same locations check interleaving against the earlier write-power words, which exposes any address offset or location restart error. Constant-power, normal, DVD and detector-only frames, a bundle sent without sync, and a mode switch after the sync edge all check that nothing outside an armed mode-0/mode-2 capture reaches the RAM or the power setting. The count of ready-low cycles after each capture separates the one-word and three-word store paths.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    M_TSTEP  = 3'd0,
    M_WCONST = 3'd1,
    M_TREAD  = 3'd2,
    M_NREAD  = 3'd3,
    M_DVD    = 3'd4,
    M_DET    = 3'd5,
    M_RSV6   = 3'd6,
    M_RSV7   = 3'd7
  } cap_mode_e;

  localparam int NUM_CH = 4;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/cap_power_step.sv
module cap_power_step #(
  parameter int PWR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PWR_W-1:0] base_i,
  input  logic             tick_i,
  input  logic             step_mode_i,
  output logic [PWR_W-1:0] pwr_o
);
  localparam logic [PWR_W-1:0] PWR_MAX = {PWR_W{1'b1}};

  logic             first_q;
  logic [PWR_W-1:0] pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= '0;
      first_q <= 1'b1;
    end else if (start_i) begin
      pwr_q   <= base_i;
      first_q <= 1'b1;
    end else if (tick_i) begin
      first_q <= 1'b0;
      if (step_mode_i && !first_q && (pwr_q != PWR_MAX))
        pwr_q <= pwr_q + PWR_W'(1);
    end
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[w] <= '0;
      else if (we_i && (waddr_i == AW'(w)))       mem[w] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int LOC_W = 4,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     rise_i,
  input  cap_mode_e                mode_i,
  input  logic [LOC_W:0]           num_loc_i,
  input  logic                     smp_valid_i,
  input  logic [NUM_CH-1:0][DW-1:0] chan_i,
  output logic                     ready_o,
  output logic                     done_o,
  output logic                     active_o,
  output logic                     we_o,
  output logic [LOC_W+1:0]         waddr_o,
  output logic [DW-1:0]            wdata_o
);
  localparam logic [LOC_W:0] LOC_N = {1'b1, {LOC_W{1'b0}}};

  logic                      running_q, done_q, armed_q, arm_rd_q, busy_q, busy_rd_q;
  logic [1:0]                wsel_q;
  logic [LOC_W-1:0]          loc_q;
  logic [NUM_CH-1:0][DW-1:0] lat_q;

  logic [LOC_W:0] limit, loc_nx;
  logic           cap_mode, last_word, finish, accept;

  always_comb begin
    limit     = ((num_loc_i == '0) || (num_loc_i > LOC_N)) ? LOC_N : num_loc_i;
    loc_nx    = {1'b0, loc_q} + (LOC_W+1)'(1);
    cap_mode  = (mode_i == M_TSTEP) || (mode_i == M_TREAD);
    last_word = busy_rd_q ? (wsel_q == 2'd3) : 1'b1;
    finish    = busy_q && last_word && (loc_nx == limit);
    accept    = armed_q && smp_valid_i && !busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      armed_q   <= 1'b0;
      arm_rd_q  <= 1'b0;
      busy_q    <= 1'b0;
      busy_rd_q <= 1'b0;
      wsel_q    <= '0;
      loc_q     <= '0;
      lat_q     <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      done_q    <= 1'b0;
      armed_q   <= 1'b0;
      busy_q    <= 1'b0;
      wsel_q    <= '0;
      loc_q     <= '0;
    end else begin
      if (busy_q) begin
        if (last_word) begin
          busy_q <= 1'b0;
          loc_q  <= loc_nx[LOC_W-1:0];
          if (finish) begin
            done_q    <= 1'b1;
            running_q <= 1'b0;
            armed_q   <= 1'b0;
          end
        end else begin
          wsel_q <= wsel_q + 2'd1;
        end
      end
      if (accept) begin
        lat_q     <= chan_i;
        armed_q   <= 1'b0;
        busy_q    <= 1'b1;
        busy_rd_q <= arm_rd_q;
        wsel_q    <= arm_rd_q ? 2'd1 : 2'd0;
      end
      if (rise_i && running_q && !finish) begin
        armed_q <= cap_mode;
        if (cap_mode) arm_rd_q <= (mode_i == M_TREAD);
      end
    end
  end

  assign ready_o  = ~busy_q;
  assign done_o   = done_q;
  assign active_o = running_q;
  assign we_o     = busy_q;
  assign waddr_o  = {loc_q, wsel_q};
  assign wdata_o  = lat_q[wsel_q];
endmodule

// File: rtl/cal_capture_ctrl.sv
module cal_capture_ctrl
  import cap_pkg::*;
#(
  parameter int LOC_W = 4,
  parameter int DW    = 8,
  parameter int PWR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         mode_i,
  input  logic [LOC_W:0]     num_loc_i,
  input  logic [PWR_W-1:0]   pwr_base_i,
  input  logic               sync_i,
  input  logic               smp_valid_i,
  output logic               smp_ready_o,
  input  logic [DW-1:0]      smp_pw_i,
  input  logic [DW-1:0]      smp_a1_i,
  input  logic [DW-1:0]      smp_a2_i,
  input  logic [DW-1:0]      smp_calf_i,
  input  logic [LOC_W+1:0]   rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [PWR_W-1:0]   pwr_o,
  output logic               done_o
);
  localparam int ADDR_W = LOC_W + 2;

  cap_mode_e                 mode;
  logic                      rise, active;
  logic                      ram_we;
  logic [ADDR_W-1:0]         ram_wa;
  logic [DW-1:0]             ram_wd;
  logic [NUM_CH-1:0][DW-1:0] chan;

  assign mode = cap_mode_e'(mode_i);
  assign chan = {smp_calf_i, smp_a2_i, smp_a1_i, smp_pw_i};

  cap_sync_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  cap_seq #(.LOC_W(LOC_W), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rise_i      (rise),
    .mode_i      (mode),
    .num_loc_i   (num_loc_i),
    .smp_valid_i (smp_valid_i),
    .chan_i      (chan),
    .ready_o     (smp_ready_o),
    .done_o      (done_o),
    .active_o    (active),
    .we_o        (ram_we),
    .waddr_o     (ram_wa),
    .wdata_o     (ram_wd)
  );

  cap_power_step #(.PWR_W(PWR_W)) u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_i      (pwr_base_i),
    .tick_i      (rise & active),
    .step_mode_i (mode == M_TSTEP),
    .pwr_o       (pwr_o)
  );

  cap_ram #(.AW(ADDR_W), .DW(DW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ram_we),
    .waddr_i (ram_wa),
    .wdata_i (ram_wd),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/cal_capture_chk.sv
module cal_capture_chk #(
  parameter int PWR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sync_i,
  input logic             smp_ready_o,
  input logic [PWR_W-1:0] pwr_o,
  input logic             done_o,
  input logic             ram_we
);
  logic sync_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_seen <= 1'b0;
    else        sync_seen <= sync_i;
  end

  // R5
  pwr_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_o != $past(pwr_o)) |-> ($past(start_i) || $past(sync_i && !sync_seen)));

  // R5
  pwr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_i) |-> (pwr_o >= $past(pwr_o)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ram_we));

  // R8
  we_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !smp_ready_o);
endmodule

bind cal_capture_ctrl cal_capture_chk #(.PWR_W(PWR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .sync_i      (sync_i),
  .smp_ready_o (smp_ready_o),
  .pwr_o       (pwr_o),
  .done_o      (done_o),
  .ram_we      (ram_we)
);

// File: tb/cal_capture_ctrl_tb.sv
`timescale 1ns/1ps
module cal_capture_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'd3;
  logic [4:0] num_loc_i = 5'd4;
  logic [7:0] pwr_base_i = 8'd0;
  logic       sync_i = 1'b0;
  logic       smp_valid_i = 1'b0;
  logic       smp_ready_o;
  logic [7:0] smp_pw_i = 0, smp_a1_i = 0, smp_a2_i = 0, smp_calf_i = 0;
  logic [5:0] rd_addr_i = 0;
  logic [7:0] rd_data_o, pwr_o;
  logic       done_o;

  always #2.5 clk = ~clk;

  cal_capture_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .num_loc_i(num_loc_i), .pwr_base_i(pwr_base_i), .sync_i(sync_i),
    .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .smp_pw_i(smp_pw_i), .smp_a1_i(smp_a1_i), .smp_a2_i(smp_a2_i),
    .smp_calf_i(smp_calf_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pwr_o(pwr_o), .done_o(done_o)
  );

  int checks = 0, failures = 0;
  logic [7:0]  exp_mem [64];
  logic [13:0] exp_q [$];
  string       rd_tag = "R11";
  bit          rd_req = 0;
  int          m_pwr, m_loc, m_lim;
  bit          m_act = 0, m_first = 1, m_done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data one cycle after each requested address
  initial forever begin
    @(posedge clk); #1;
    if (rd_req && exp_q.size() > 0) begin
      logic [13:0] it;
      it = exp_q.pop_front();
      chk(rd_data_o == it[7:0], rd_tag, $sformatf("ram[%0d]", it[13:8]), rd_data_o, it[7:0]);
    end
  end

  task automatic verify_ram(input string tag);
    rd_tag = tag;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      rd_addr_i = a[5:0];
      rd_req = 1;
      exp_q.push_back({a[5:0], exp_mem[a]});
    end
    @(negedge clk);
    rd_req = 0;
    chk(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic do_start(input int base, input int num);
    @(negedge clk);
    pwr_base_i = base[7:0]; num_loc_i = num[4:0]; start_i = 1;
    @(negedge clk);
    start_i = 0;
    m_pwr = base; m_first = 1; m_loc = 0; m_act = 1; m_done = 0;
    m_lim = (num == 0 || num > 16) ? 16 : num;
    chk(pwr_o == m_pwr[7:0], "R5", "pwr after start", pwr_o, m_pwr);
    chk(done_o == 1'b0, "R9", "done after start", done_o, 0);
  endtask

  task automatic frame(input int md, input int md_after, input int pw, input int a1,
                       input int a2, input int cf, input string ptag);
    bit cap, rdm;
    int lows, exp_lows;
    cap = m_act && (md == 0 || md == 2);
    rdm = (md == 2);
    if (m_act) begin
      if (md == 0 && !m_first) m_pwr = (m_pwr < 255) ? m_pwr + 1 : 255;
      m_first = 0;
    end
    @(negedge clk);
    mode_i = md[2:0]; sync_i = 1;
    @(negedge clk);
    mode_i = md_after[2:0];
    chk(pwr_o == m_pwr[7:0], ptag, "pwr after sync", pwr_o, m_pwr);
    smp_pw_i = pw[7:0]; smp_a1_i = a1[7:0]; smp_a2_i = a2[7:0]; smp_calf_i = cf[7:0];
    smp_valid_i = 1;
    @(negedge clk);
    smp_valid_i = 0;
    lows = 0;
    while (!smp_ready_o) begin lows++; @(negedge clk); end
    exp_lows = cap ? (rdm ? 3 : 1) : 0;
    chk(lows == exp_lows, "R8", "ready-low cycles", lows, exp_lows);
    if (cap) begin
      if (rdm) begin
        exp_mem[m_loc*4+1] = a1[7:0];
        exp_mem[m_loc*4+2] = a2[7:0];
        exp_mem[m_loc*4+3] = cf[7:0];
      end else begin
        exp_mem[m_loc*4] = pw[7:0];
      end
      m_loc++;
      if (m_loc == m_lim) begin m_act = 0; m_done = 1; end
    end
    chk(done_o == m_done, "R9", "done after frame", done_o, m_done);
    sync_i = 0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(pwr_o == 8'd0, "R10", "pwr reset", pwr_o, 0);
    chk(done_o == 1'b0, "R10", "done reset", done_o, 0);
    chk(smp_ready_o == 1'b1, "R10", "ready reset", smp_ready_o, 1);
    verify_ram("R10");

    // R2 R5 stepped test write
    do_start(100, 4);
    for (int k = 0; k < 4; k++) frame(0, 0, 16 + k, 0, 0, 0, "R5");
    frame(0, 0, 99, 0, 0, 0, "R9");
    verify_ram("R2");

    // R3 read-back beside write-power words
    do_start(7, 4);
    for (int k = 0; k < 4; k++) frame(2, 2, 0, 40 + k, 80 + k, 120 + k, "R3");
    verify_ram("R3");

    // R7 bundle with no sync is dropped; mode switched after edge keeps capture
    do_start(0, 4);
    @(negedge clk);
    smp_valid_i = 1; smp_a1_i = 8'hEE; smp_pw_i = 8'hEE;
    @(negedge clk);
    smp_valid_i = 0;
    chk(smp_ready_o == 1'b1, "R7", "ready after dropped bundle", smp_ready_o, 1);
    frame(2, 5, 0, 200, 201, 202, "R7");
    frame(5, 2, 0, 210, 211, 212, "R7");
    verify_ram("R7");

    // R5 saturation
    do_start(254, 3);
    for (int k = 0; k < 3; k++) frame(0, 0, 60 + k, 0, 0, 0, "R5");
    chk(pwr_o == 8'd255, "R5", "saturated pwr", pwr_o, 255);

    // R6 R1 constant-power write and read modes touch nothing
    do_start(50, 4);
    frame(1, 1, 1, 2, 3, 4, "R6");
    frame(1, 1, 5, 6, 7, 8, "R6");
    frame(3, 3, 9, 9, 9, 9, "R1");
    frame(4, 4, 9, 9, 9, 9, "R1");
    frame(7, 7, 9, 9, 9, 9, "R1");
    frame(1, 1, 9, 9, 9, 9, "R6");
    verify_ram("R1");

    // R4 detector-only
    do_start(9, 1);
    for (int k = 0; k < 3; k++) frame(5, 5, 77, 77, 77, 77, "R4");
    chk(done_o == 1'b0, "R4", "done in detector-only", done_o, 0);
    chk(pwr_o == 8'd9, "R4", "pwr in detector-only", pwr_o, 9);
    verify_ram("R4");

    // R9 count 0 means 16
    do_start(1, 0);
    for (int k = 0; k < 16; k++) begin
      if (k == 15) chk(done_o == 1'b0, "R9", "done before 16th", done_o, 0);
      frame(0, 0, 128 + k, 0, 0, 0, "R5");
    end
    verify_ram("R2");

    // R9 oversize count clamps to 16
    do_start(3, 31);
    for (int k = 0; k < 16; k++) frame(0, 0, 160 + k, 0, 0, 0, "R5");
    frame(0, 0, 5, 0, 0, 0, "R9");
    verify_ram("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule